// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital input stage of a voltage DAC that is programmed over a three-wire write port. The port has an active-low frame strobe, a serial clock and a data line. All three are sampled in a faster system clock, and the clock and strobe edges are found there. A frame holds sixteen bits and is sent most significant bit first. Its two leading bits select the output state. The fourteen bits after them carry the code left-justified, and a narrower build keeps only the upper part of that field.

When a frame completes, the code and the output-state mode are loaded together, and a single-cycle update pulse marks the load. A frame that the strobe cuts short changes nothing. The drive-enable flag tells the analog output stage whether to drive the pin or to apply one of the power-down terminations.

The update pulse acts as a valid signal that cannot be stalled. There is no ready input, so the consumer has to take the code and mode in the cycle of the pulse, or read them later from the held outputs. Those outputs keep their values until the next committed frame.

Top module: `sdac_wr_port`

## Requirements
- R1: After reset, code_o is zero, pd_mode_o is 00, drive_en_o is 1 and upd_o is 0. They keep these values until the first frame is committed.
- R2: A frame starts when the strobe falls. On each falling edge of the serial clock one data bit is taken in, most significant bit first. The sixteenth falling edge commits the frame: pd_mode_o takes frame bits 15:14 and code_o takes frame bits 13 down to 14-CODE_W.
- R3: The mode encoding is 00 = normal drive, 01 = off with 1 kΩ to ground, 10 = off with 100 kΩ to ground, 11 = off with the output high-impedance. drive_en_o is 1 only when the mode is 00.
- R4: If the strobe rises before the sixteenth falling edge, the frame is dropped. No update pulse follows, and code_o and pd_mode_o keep their values.
- R5: Serial clock falling edges after the sixteenth, while the strobe stays low, are ignored. A new frame starts only after the strobe goes high and then falls again.
- R6: upd_o is high for exactly one system clock cycle for each committed frame.
- R7: code_o and pd_mode_o change only in a cycle where upd_o is high. Entering or leaving a power-down mode alone does not clear or change the stored code.
- R8: With CODE_W below 14, frame bits 13-CODE_W down to 0 are ignored. A frame whose only set bits lie there loads code zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_n_i | input | 1 | Active-low frame strobe from the host |
| sck_i | input | 1 | Serial clock from the host; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data from the host, most significant bit first |
| code_o | output | CODE_W | Stored DAC code |
| pd_mode_o | output | 2 | Stored output-state mode |
| upd_o | output | 1 | One-cycle pulse when code and mode are loaded |
| drive_en_o | output | 1 | High when the output amplifier should drive the pin |

## Verification
The outputs are registers loaded only on a commit, so a wrong internal state shows up at one of two points. A miscounted bit index or a wrong field slice appears in code_o or pd_mode_o three system cycles after the sixteenth serial clock fall. A frame tracker that failed to clear, or failed to disarm, shows up as an update pulse with no matching frame on the scoreboard, or as a missing pulse when one is due. The bench sends frames for every mode, aborted frames, frames with trailing edges and a frame with data only in the ignored low bits. It compares every pulse against a queue of expected loads and checks between pulses that the outputs hold.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Word geometry of one write frame
  localparam int FRAME_W   = 16;
  localparam int MODE_W    = 2;
  localparam int FIELD_W   = FRAME_W - MODE_W;   // width of the justified code field

  // Output-state selection carried in the leading frame bits
  typedef enum logic [MODE_W-1:0] {
    PD_DRIVE = 2'b00,
    PD_R1K   = 2'b01,
    PD_R100K = 2'b10,
    PD_HIZ   = 2'b11
  } pd_mode_e;

endpackage

// File: rtl/sdac_sync.sv
// Multi-stage level synchronizer for one asynchronous input.
module sdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdac_edge_det.sv
// Synchronizes an input and flags its falling edges in the system clock.
module sdac_edge_det #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);

  logic lvl_w;
  logic prev_q;

  sdac_sync #(.STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (d_i),
    .q_o  (lvl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_w;
  end

  assign lvl_o  = lvl_w;
  assign fall_o = prev_q & ~lvl_w;

endmodule

// File: rtl/sdac_frame_shifter.sv
// Tracks one write frame and captures only the bits that are kept.
module sdac_frame_shifter
  import sdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frm_lvl_i,   // synchronized strobe level (1 = idle)
  input  logic                     frm_fall_i,  // strobe falling edge
  input  logic                     sck_fall_i,  // serial clock falling edge
  input  logic                     sdi_i,       // synchronized data
  output logic                     armed_o,
  output logic                     commit_o,
  output logic [MODE_W+CODE_W-1:0] word_o
);

  localparam int KEEP_W = MODE_W + CODE_W;
  localparam int CNT_W  = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [KEEP_W-1:0] keep_q;
  logic [KEEP_W-1:0] keep_nxt;
  logic              take;

  assign take     = armed_q & sck_fall_i & ~frm_lvl_i;
  assign commit_o = take & (cnt_q == LAST_IDX);
  assign armed_o  = armed_q;
  assign word_o   = keep_nxt;

  // Bit counter and frame state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (frm_lvl_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (frm_fall_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) armed_q <= 1'b0;
    end
  end

  // Position-addressed capture: frame bit n (n counted from first) lands at KEEP_W-1-n
  for (genvar i = 0; i < KEEP_W; i++) begin : g_keep
    localparam logic [CNT_W-1:0] POS = CNT_W'(KEEP_W - 1 - i);
    logic hit;
    assign hit         = take & (cnt_q == POS);
    assign keep_nxt[i] = hit ? sdi_i : keep_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        keep_q[i] <= 1'b0;
      else if (frm_lvl_i || frm_fall_i)  keep_q[i] <= 1'b0;
      else if (hit)                      keep_q[i] <= sdi_i;
    end
  end

endmodule

// File: rtl/sdac_cmd_regs.sv
// Holds the committed code and output-state mode.
module sdac_cmd_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic [MODE_W+CODE_W-1:0] word_i,
  output logic [CODE_W-1:0]        code_o,
  output pd_mode_e                 mode_o,
  output logic                     upd_o,
  output logic                     drive_en_o
);

  localparam int KEEP_W = MODE_W + CODE_W;

  pd_mode_e new_mode;
  assign new_mode = pd_mode_e'(word_i[KEEP_W-1 -: MODE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o     <= '0;
      mode_o     <= PD_DRIVE;
      upd_o      <= 1'b0;
      drive_en_o <= 1'b1;
    end else begin
      upd_o <= commit_i;
      if (commit_i) begin
        code_o     <= word_i[CODE_W-1:0];
        mode_o     <= new_mode;
        drive_en_o <= (new_mode == PD_DRIVE);
      end
    end
  end

endmodule

// File: rtl/sdac_wr_port.sv
// Serial write port of a voltage DAC: frame capture and command registers.
module sdac_wr_port
  import sdac_pkg::*;
#(
  parameter int CODE_W      = 10,   // 1..FIELD_W
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        pd_mode_o,
  output logic              upd_o,
  output logic              drive_en_o
);

  localparam int KEEP_W = MODE_W + CODE_W;

  logic              frm_lvl;
  logic              frm_fall;
  logic              sck_lvl;
  logic              sck_fall;
  logic              sdi_lvl;
  logic              armed;
  logic              commit;
  logic [KEEP_W-1:0] word;
  pd_mode_e          mode_q;

  sdac_edge_det #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_frm (
    .clk(clk), .rst_n(rst_n), .d_i(frm_n_i), .lvl_o(frm_lvl), .fall_o(frm_fall)
  );

  sdac_edge_det #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i), .lvl_o(sck_lvl), .fall_o(sck_fall)
  );

  sdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_lvl)
  );

  sdac_frame_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_lvl_i (frm_lvl),
    .frm_fall_i(frm_fall),
    .sck_fall_i(sck_fall & ~sck_lvl),
    .sdi_i     (sdi_lvl),
    .armed_o   (armed),
    .commit_o  (commit),
    .word_o    (word)
  );

  sdac_cmd_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .word_i    (word),
    .code_o    (code_o),
    .mode_o    (mode_q),
    .upd_o     (upd_o),
    .drive_en_o(drive_en_o)
  );

  assign pd_mode_o = mode_q;

endmodule

// File: rtl/sdac_wr_port_chk.sv
// Property checker attached to the write port.
module sdac_wr_port_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_lvl,
  input logic              armed,
  input logic [CODE_W-1:0] code_o,
  input logic [1:0]        pd_mode_o,
  input logic              upd_o,
  input logic              drive_en_o
);

  AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_o == (pd_mode_o == 2'b00)); // R3

  AST_NO_UPD_OPEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_lvl |=> !upd_o); // R4

  AST_NO_UPD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !upd_o); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o); // R6

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(code_o) && $stable(pd_mode_o))); // R7

endmodule

bind sdac_wr_port sdac_wr_port_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_lvl   (frm_lvl),
  .armed     (armed),
  .code_o    (code_o),
  .pd_mode_o (pd_mode_o),
  .upd_o     (upd_o),
  .drive_en_o(drive_en_o)
);

// File: tb/sim_sdac_wr_port.sv
module sim_sdac_wr_port;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4 * CLK_PERIOD;
  localparam int CODE_W     = 10;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [1:0]        mode;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_n = 1'b1;
  logic sck = 1'b1;
  logic sdi = 1'b0;
  logic [CODE_W-1:0] code_o;
  logic [1:0] pd_mode_o;
  logic upd_o;
  logic drive_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_upd = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  logic [CODE_W-1:0] held_code = '0;
  logic [1:0] held_mode = '0;
  logic prev_upd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_wr_port #(.CODE_W(CODE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_n_i(frm_n), .sck_i(sck), .sdi_i(sdi),
    .code_o(code_o), .pd_mode_o(pd_mode_o), .upd_o(upd_o), .drive_en_o(drive_en_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: send a frame; push the expected load when it will complete.
  task automatic send(input logic [15:0] w, input int falls, input bit open, input bit close);
    exp_t e;
    if (open && falls >= 16) begin
      e.code = w[13 -: CODE_W];
      e.mode = w[15:14];
      exp_q.push_back(e);
    end
    if (open) begin
      frm_n = 1'b0;
      #(HALF_SCK);
    end
    for (int i = 0; i < falls; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      #(HALF_SCK);
      sck = 1'b0;
      #(HALF_SCK);
      sck = 1'b1;
    end
    #(HALF_SCK);
    if (close) frm_n = 1'b1;
    #(2 * HALF_SCK);
  endtask

  // Monitor: compare every update against the scoreboard, check holds between.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (upd_o) begin
        n_upd++;
        check("R6 pulse width", 32'(prev_upd), 32'd0);
        if (exp_q.size() == 0) begin
          check("R5 unexpected update", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R2/R8 code", 32'(code_o), 32'(e.code));
          check("R2 mode", 32'(pd_mode_o), 32'(e.mode));
          check("R3 drive enable", 32'(drive_en_o), 32'(e.mode == 2'b00));
        end
        held_code = code_o;
        held_mode = pd_mode_o;
      end else begin
        check("R7 code hold", 32'(code_o), 32'(held_code));
        check("R7 mode hold", 32'(pd_mode_o), 32'(held_mode));
      end
      prev_upd = upd_o;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R1: reset values
    check("R1 code", 32'(code_o), 32'd0);
    check("R1 mode", 32'(pd_mode_o), 32'd0);
    check("R1 drive", 32'(drive_en_o), 32'd1);
    check("R1 upd", 32'(upd_o), 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 code after idle", 32'(code_o), 32'd0);

    // R2/R3: each mode and several data patterns
    send(16'h3FFF, 16, 1, 1);
    send(16'h5A5C, 16, 1, 1);   // R3 mode 01
    send(16'h8AAA, 16, 1, 1);   // R3 mode 10
    send(16'hC555, 16, 1, 1);   // R3 mode 11
    send(16'h0C30, 16, 1, 1);   // leave power-down, R7
    // R8: only ignored low bits set
    send(16'h000F, 16, 1, 1);

    // R4: aborted frames
    base = n_upd;
    send(16'h7FFF, 15, 1, 1);
    send(16'hBFFF, 3, 1, 1);
    check("R4 no update", 32'(n_upd), 32'(base));
    check("R4 code kept", 32'(code_o), 32'(held_code));
    check("R4 mode kept", 32'(pd_mode_o), 32'd0);

    // R5: trailing edges, then edges with strobe still low
    send(16'h2468, 24, 1, 0);
    base = n_upd;
    send(16'h9999, 16, 0, 1);
    check("R5 no re-arm", 32'(n_upd), 32'(base));
    check("R5 code kept", 32'(code_o), 32'(16'h2468 >> 4));
    send(16'h1357, 16, 1, 1);

    repeat (20) @(negedge clk);
    check("R2 all frames seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule